// File: doc/BRIEF.md
# Core Supply Domain Sequencer

This block switches the supply of a single processor core off and back on, in the only order that keeps the core and its neighbours safe. It drives the domain power switch, the isolation clamps on the core outputs, the core power-on reset (active low), the L1 reset-disable level and the debug power-up flag. It also reports whether the domain is off, on or in transition.

A power-down request is honoured only once the core reports that it is idle in its wait-for-interrupt standby. Until then the sequencer waits, and a cancel input can abandon the attempt. The walk-down then lowers debug power-up, raises the clamps and finally cuts power while asserting reset.

A power-up request first holds reset and the L1 strap low with power still off, then closes the switch. Clamps are released only after the switch's power-good has been seen high, with reset held low, for a programmable number of consecutive cycles. Reset is released after that, and debug power-up last. Power-good and the idle indication pass through a configurable synchroniser before use.

Top module: `pwr_dom_seq`

## Requirements
- R1: After controller reset the outputs are: power enable 0, clamp 1, core reset 0 (asserted), L1 reset-disable 0, debug power-up 0, status 2'b00 (off).
- R2: A power-up request seen in the off state gives one cycle with power still off and reset, L1 reset-disable and debug power-up all low. Power enable then rises while those three stay low. L1 reset-disable is low in every cycle that reset is asserted.
- R3: Clamps are released only after the synchronised power-good has been high for RST_HOLD consecutive cycles with power enabled and reset asserted. A low power-good restarts that count.
- R4: The cycle after the clamps are released, reset is deasserted. The cycle after that, debug power-up rises and status becomes 2'b01 (on). Debug power-up is never high while reset or clamp is asserted.
- R5: A power-down request in the on state moves status to 2'b10 (busy) with all other outputs unchanged. The sequence advances only once the synchronised idle indication is high.
- R6: A cancel while waiting for idle returns the block to the on state (status 2'b01, debug power-up still high). Cancel has priority over idle seen in the same cycle.
- R7: Once idle is seen, debug power-up falls first. The next cycle clamps are set with power still on. The cycle after that, power enable falls, reset is asserted and status returns to 2'b00.
- R8: Status is 2'b10 in every transitional state and never 2'b11. A request that does not match the current state (power-up while on or busy, power-down while off or busy) has no effect.
- R9: The clamps are asserted in every cycle that power enable is low.
- R10: Power-good and idle take effect SYNC_STAGES+1 clock edges after they are driven. With defaults, a power-up request with power-good following power enable reaches the on state 4+SYNC_STAGES+RST_HOLD cycles after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| up_req_i | input | 1 | Request to power the domain up |
| dn_req_i | input | 1 | Request to power the domain down |
| cancel_i | input | 1 | Abandon a power-down that is still waiting for idle |
| core_idle_i | input | 1 | Core wait-for-interrupt standby indication |
| pwr_good_i | input | 1 | Power-good from the domain switch |
| pwr_en_o | output | 1 | Domain power switch enable |
| clamp_o | output | 1 | Core output clamp enable |
| core_rst_n_o | output | 1 | Core power-on reset, active low |
| l1_rst_dis_o | output | 1 | L1 reset-disable level |
| dbg_pwrup_o | output | 1 | Debug power-up indication |
| status_o | output | 2 | 00 off, 01 on, 10 busy |

## Verification
The assertions assume that power-good and idle may change on any cycle, including glitches while power is off. They place no ordering demand on the request inputs, so the bench drives up, down and cancel requests at random in every state, and most of those requests are meant to be ignored. Power-good is raised mostly while power enable is high and dropped randomly to restart the hold count. A small rate of spurious power-good while power is off checks that the clamps stay on regardless.

// File: rtl/pwr_dom_seq_pkg.sv
package pwr_dom_seq_pkg;

   typedef enum logic [3:0] {
      PS_OFF      = 4'd0,
      PS_UP_RST   = 4'd1,
      PS_UP_PWR   = 4'd2,
      PS_UP_UNCLP = 4'd3,
      PS_UP_RLS   = 4'd4,
      PS_ON       = 4'd5,
      PS_DN_WAIT  = 4'd6,
      PS_DN_DBG   = 4'd7,
      PS_DN_CLP   = 4'd8
   } pseq_state_e;

   localparam logic [1:0] STAT_OFF  = 2'b00;
   localparam logic [1:0] STAT_ON   = 2'b01;
   localparam logic [1:0] STAT_BUSY = 2'b10;

   typedef struct packed {
      logic       pwr_en;
      logic       clamp;
      logic       rst_n;
      logic       l1_dis;
      logic       dbg;
      logic [1:0] status;
   } pseq_out_t;

endpackage

// File: rtl/pds_sync.sv
module pds_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else if (s == 0) stage_q[s] <= d_i;
               else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
         assign q_o = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pds_hold_cnt.sv
module pds_hold_cnt #(
   parameter int RST_HOLD = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic pg_i,
   output logic done_o
);

   localparam int CW = (RST_HOLD < 2) ? 1 : $clog2(RST_HOLD);
   localparam logic [CW-1:0] LAST = CW'(RST_HOLD - 1);

   logic [CW-1:0] cnt_q;
   logic          live;

   assign live   = run_i & pg_i;
   assign done_o = live & (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (live && !done_o) cnt_q <= cnt_q + 1'b1;
      else                     cnt_q <= '0;
   end

endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
   import pwr_dom_seq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        up_req_i,
   input  logic        dn_req_i,
   input  logic        cancel_i,
   input  logic        idle_s_i,
   input  logic        hold_done_i,
   output logic        hold_run_o,
   output pseq_state_e state_o
);

   pseq_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PS_OFF:      if (up_req_i) state_d = PS_UP_RST;
         PS_UP_RST:   state_d = PS_UP_PWR;
         PS_UP_PWR:   if (hold_done_i) state_d = PS_UP_UNCLP;
         PS_UP_UNCLP: state_d = PS_UP_RLS;
         PS_UP_RLS:   state_d = PS_ON;
         PS_ON:       if (dn_req_i) state_d = PS_DN_WAIT;
         PS_DN_WAIT: begin
            if (cancel_i)      state_d = PS_ON;
            else if (idle_s_i) state_d = PS_DN_DBG;
         end
         PS_DN_DBG:   state_d = PS_DN_CLP;
         PS_DN_CLP:   state_d = PS_OFF;
         default:     state_d = PS_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PS_OFF;
      else        state_q <= state_d;
   end

   assign hold_run_o = (state_q == PS_UP_PWR);
   assign state_o    = state_q;

endmodule

// File: rtl/pds_out_dec.sv
module pds_out_dec
   import pwr_dom_seq_pkg::*;
#(
   parameter bit L1_DIS_RUN = 1'b0
) (
   input  pseq_state_e state_i,
   output pseq_out_t   out_o
);

   always_comb begin
      out_o = '{pwr_en: 1'b0, clamp: 1'b1, rst_n: 1'b0, l1_dis: 1'b0,
                dbg: 1'b0, status: STAT_BUSY};
      unique case (state_i)
         PS_OFF:      out_o.status = STAT_OFF;
         PS_UP_RST:   ;
         PS_UP_PWR:   out_o.pwr_en = 1'b1;
         PS_UP_UNCLP: begin
            out_o.pwr_en = 1'b1;
            out_o.clamp  = 1'b0;
         end
         PS_UP_RLS, PS_DN_DBG: begin
            out_o.pwr_en = 1'b1;
            out_o.clamp  = 1'b0;
            out_o.rst_n  = 1'b1;
            out_o.l1_dis = L1_DIS_RUN;
         end
         PS_ON, PS_DN_WAIT: begin
            out_o.pwr_en = 1'b1;
            out_o.clamp  = 1'b0;
            out_o.rst_n  = 1'b1;
            out_o.l1_dis = L1_DIS_RUN;
            out_o.dbg    = 1'b1;
            if (state_i == PS_ON) out_o.status = STAT_ON;
         end
         PS_DN_CLP: begin
            out_o.pwr_en = 1'b1;
            out_o.rst_n  = 1'b1;
            out_o.l1_dis = L1_DIS_RUN;
         end
         default: out_o.status = STAT_OFF;
      endcase
   end

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
   import pwr_dom_seq_pkg::*;
#(
   parameter int RST_HOLD    = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit L1_DIS_RUN  = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       up_req_i,
   input  logic       dn_req_i,
   input  logic       cancel_i,
   input  logic       core_idle_i,
   input  logic       pwr_good_i,
   output logic       pwr_en_o,
   output logic       clamp_o,
   output logic       core_rst_n_o,
   output logic       l1_rst_dis_o,
   output logic       dbg_pwrup_o,
   output logic [1:0] status_o
);

   generate
      if (RST_HOLD < 1) begin : g_bad_hold
         $error("pwr_dom_seq: RST_HOLD must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 8) begin : g_bad_sync
         $error("pwr_dom_seq: SYNC_STAGES must lie in 0..8");
      end
   endgenerate

   logic [1:0]  raw_in, sync_out;
   logic        pg_s, idle_s, hold_run, hold_done;
   pseq_state_e state;
   pseq_out_t   outs;

   assign raw_in = {pwr_good_i, core_idle_i};
   assign pg_s   = sync_out[1];
   assign idle_s = sync_out[0];

   pds_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (sync_out)
   );

   pds_hold_cnt #(.RST_HOLD(RST_HOLD)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (hold_run),
      .pg_i   (pg_s),
      .done_o (hold_done)
   );

   pds_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .up_req_i    (up_req_i),
      .dn_req_i    (dn_req_i),
      .cancel_i    (cancel_i),
      .idle_s_i    (idle_s),
      .hold_done_i (hold_done),
      .hold_run_o  (hold_run),
      .state_o     (state)
   );

   pds_out_dec #(.L1_DIS_RUN(L1_DIS_RUN)) u_dec (
      .state_i (state),
      .out_o   (outs)
   );

   assign pwr_en_o     = outs.pwr_en;
   assign clamp_o      = outs.clamp;
   assign core_rst_n_o = outs.rst_n;
   assign l1_rst_dis_o = outs.l1_dis;
   assign dbg_pwrup_o  = outs.dbg;
   assign status_o     = outs.status;

endmodule

// File: rtl/pds_checker.sv
module pds_checker #(
   parameter int RST_HOLD = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       pwr_en_o,
   input logic       clamp_o,
   input logic       core_rst_n_o,
   input logic       l1_rst_dis_o,
   input logic       dbg_pwrup_o,
   input logic [1:0] status_o
);

   localparam int HW = $clog2(RST_HOLD + 2) + 1;
   logic [HW-1:0] held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_q <= '0;
      else if (pwr_en_o && !core_rst_n_o) begin
         if (held_q != '1) held_q <= held_q + 1'b1;
      end else held_q <= '0;
   end

   p_clamp_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en_o |-> clamp_o);

   p_l1_low_in_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !core_rst_n_o |-> !l1_rst_dis_o);

   p_clamp_rel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clamp_o) |-> pwr_en_o && !core_rst_n_o && (held_q >= HW'(RST_HOLD)));

   p_rst_after_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_rst_n_o) |-> !clamp_o && $past(!clamp_o));

   p_dbg_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_pwrup_o |-> core_rst_n_o && !clamp_o && pwr_en_o);

   p_dbg_after_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dbg_pwrup_o) |-> $past(core_rst_n_o));

   p_clamp_after_dbg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(clamp_o) && pwr_en_o) |-> $past(!dbg_pwrup_o));

   p_pwr_off_clamped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_en_o) |-> $past(clamp_o) && !core_rst_n_o && (status_o == 2'b00));

   p_status_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      status_o != 2'b11);

endmodule

bind pwr_dom_seq pds_checker #(.RST_HOLD(RST_HOLD)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pwr_en_o     (pwr_en_o),
   .clamp_o      (clamp_o),
   .core_rst_n_o (core_rst_n_o),
   .l1_rst_dis_o (l1_rst_dis_o),
   .dbg_pwrup_o  (dbg_pwrup_o),
   .status_o     (status_o)
);

// File: tb/pwr_dom_seq_tb.sv
`timescale 1ns/1ps
module pwr_dom_seq_tb;

   localparam int HOLD = 4;
   localparam int SYNC = 2;

   typedef enum int {M_OFF, M_URST, M_UPWR, M_UNCL, M_URLS, M_ON,
                     M_WAIT, M_DDBG, M_DCLP} mstate_e;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic up_req = 1'b0, dn_req = 1'b0, cancel = 1'b0, idle = 1'b0, pg = 1'b0;
   logic pwr_en, clamp, core_rst_n, l1_dis, dbg;
   logic [1:0] status;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit rand_mode = 1'b0, follow_pg = 1'b0, done = 1'b0;

   always #2 clk = ~clk;

   pwr_dom_seq #(.RST_HOLD(HOLD), .SYNC_STAGES(SYNC), .L1_DIS_RUN(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .up_req_i(up_req), .dn_req_i(dn_req),
      .cancel_i(cancel), .core_idle_i(idle), .pwr_good_i(pg),
      .pwr_en_o(pwr_en), .clamp_o(clamp), .core_rst_n_o(core_rst_n),
      .l1_rst_dis_o(l1_dis), .dbg_pwrup_o(dbg), .status_o(status));

   // reference model of the requirements
   mstate_e ms;
   logic [SYNC-1:0] m_pg, m_idle;
   int m_cnt;

   always @(posedge clk) begin
      if (!rst_n) begin
         ms <= M_OFF; m_pg <= '0; m_idle <= '0; m_cnt <= 0;
      end else begin
         m_pg   <= {m_pg[SYNC-2:0], pg};
         m_idle <= {m_idle[SYNC-2:0], idle};
         m_cnt  <= 0;
         case (ms)
            M_OFF:  if (up_req) ms <= M_URST;
            M_URST: ms <= M_UPWR;
            M_UPWR: if (m_pg[SYNC-1]) begin
                       if (m_cnt == HOLD-1) ms <= M_UNCL;
                       else m_cnt <= m_cnt + 1;
                    end
            M_UNCL: ms <= M_URLS;
            M_URLS: ms <= M_ON;
            M_ON:   if (dn_req) ms <= M_WAIT;
            M_WAIT: if (cancel) ms <= M_ON;
                    else if (m_idle[SYNC-1]) ms <= M_DDBG;
            M_DDBG: ms <= M_DCLP;
            default: ms <= M_OFF;
         endcase
      end
   end

   function automatic logic [6:0] expect_out(mstate_e s);
      // {pwr_en, clamp, rst_n, l1_dis, dbg, status}
      case (s)
         M_OFF:  return 7'b0_1_0_0_0_00;
         M_URST: return 7'b0_1_0_0_0_10;
         M_UPWR: return 7'b1_1_0_0_0_10;
         M_UNCL: return 7'b1_0_0_0_0_10;
         M_URLS: return 7'b1_0_1_0_0_10;
         M_ON:   return 7'b1_0_1_0_1_01;
         M_WAIT: return 7'b1_0_1_0_1_10;
         M_DDBG: return 7'b1_0_1_0_0_10;
         default: return 7'b1_1_1_0_0_10;
      endcase
   endfunction

   function automatic string req_of(mstate_e s);
      case (s)
         M_OFF:  return "R1/R8";
         M_URST: return "R2";
         M_UPWR: return "R3/R10";
         M_UNCL, M_URLS, M_ON: return "R4";
         M_WAIT: return "R5/R6";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic tick();
      logic [6:0] got, exp;
      @(negedge clk);
      cyc++;
      got = {pwr_en, clamp, core_rst_n, l1_dis, dbg, status};
      exp = expect_out(ms);
      chk(got == exp, req_of(ms), int'(got), int'(exp));
      chk(pwr_en || clamp, "R9", int'({pwr_en, clamp}), 1);
      if (rand_mode) begin
         up_req = ($urandom_range(0, 99) < 20);
         dn_req = ($urandom_range(0, 99) < 20);
         cancel = ($urandom_range(0, 99) < 8);
         idle   = ($urandom_range(0, 99) < 30);
         pg     = pwr_en ? ($urandom_range(0, 99) < 85) : ($urandom_range(0, 99) < 3);
      end else if (follow_pg) pg = pwr_en;
   endtask

   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int n;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(pwr_en == 1'b0, "R1", pwr_en, 0);
      chk(clamp == 1'b1, "R1", clamp, 1);
      chk(core_rst_n == 1'b0, "R1", core_rst_n, 0);
      chk(dbg == 1'b0 && l1_dis == 1'b0, "R1", {dbg, l1_dis}, 0);
      chk(status == 2'b00, "R1", status, 0);
      rst_n = 1'b1;
      tick();

      // R2/R3/R4/R10: directed power-up with power-good following the switch
      follow_pg = 1'b1;
      up_req = 1'b1;
      tick();
      up_req = 1'b0;
      chk(!pwr_en && !core_rst_n && !dbg && !l1_dis, "R2",
          {pwr_en, core_rst_n, dbg, l1_dis}, 0);
      n = 1;
      for (int i = 0; i < 60 && status != 2'b01; i++) begin
         tick();
         n++;
      end
      chk(n == 4 + SYNC + HOLD, "R10", n, 4 + SYNC + HOLD);

      // R8: power-up request while on has no effect
      up_req = 1'b1;
      repeat (3) tick();
      up_req = 1'b0;
      chk(status == 2'b01 && dbg, "R8", status, 1);

      // R5: power-down waits while idle is low
      dn_req = 1'b1; idle = 1'b0;
      tick();
      dn_req = 1'b0;
      repeat (6) tick();
      chk(status == 2'b10 && dbg && !clamp && pwr_en, "R5", {status, dbg, clamp}, 6'b10_1_0);

      // R6: cancel wins over idle in the same cycle
      idle = 1'b1; cancel = 1'b1;
      for (int i = 0; i < SYNC + 2; i++) tick();
      cancel = 1'b0; idle = 1'b0;
      tick();
      chk(status == 2'b01 && dbg, "R6", {status, dbg}, 3'b01_1);

      // R7: full power-down
      dn_req = 1'b1; idle = 1'b1;
      tick();
      dn_req = 1'b0;
      for (int i = 0; i < 30 && status != 2'b00; i++) tick();
      chk(!pwr_en && clamp && !core_rst_n && status == 2'b00, "R7",
          {pwr_en, clamp, core_rst_n, status}, 5'b0_1_0_00);

      // randomised phase (model compare covers every requirement)
      follow_pg = 1'b0;
      rand_mode = 1'b1;
      for (int i = 0; i < 6000; i++) tick();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule